// File: doc/BRIEF.md
# GPIO Bank Event Detector

This block watches a bank of general-purpose input pins and records per-pin events in a status register. Each pin can be armed for a rising edge, a falling edge, a high level or a low level through four independent enable registers, with one bit per pin in each. Arming both edge enables for a pin gives detection on either edge. Any set status bit drives the single interrupt line of the bank.

Software reads the status register and writes ones back to clear the bits it has handled. Writing zeros leaves the register unchanged. Bits set by an edge stay set until they are cleared. Bits set by a level set again on the next cycle while the pin still sits at the armed level, so a handler clears, re-reads and repeats until the register reads zero. Pin inputs pass through a synchroniser before detection.

A chip with more pins than one bank holds builds several instances. The parameter for active pins trims a partly filled bank, such as the upper bank of a 54-pin set, which uses 22 pins.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset all enable registers and the status register read zero and `irq` is low.
- R2: Register addresses: 0 is status (write-one-to-clear), 1 is rising-edge enable, 2 is falling-edge enable, 3 is high-level enable and 4 is low-level enable. An enable register reads back the value last written to it. Any other address reads zero, and writes to it are ignored.
- R3: With the rising enable set, a 0-to-1 change of a pin sets its status bit. The bit is visible on the third clock edge after the pin changes: two synchroniser stages, then the status register.
- R4: With the falling enable set, a 1-to-0 change of a pin sets its status bit. A rise does not set it.
- R5: With both edge enables set, either direction of change sets the status bit.
- R6: With the high enable set, the status bit is set while the pin is high. A clear while the pin stays high is overridden on the following cycle.
- R7: With the low enable set, the status bit is set while the pin is low. A clear while the pin stays low is overridden on the following cycle.
- R8: A status write clears exactly the bits written as one. Bits written as zero are unchanged.
- R9: When an event and a clear hit the same status bit in the same cycle, the bit is left set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: A status bit stays set until it is cleared. Clearing its enable, or the pin returning to its former level, does not clear it.
- R12: Pins at or above `ACTIVE_PINS` are inert. Their enable and status bits always read zero, and their inputs never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Bank interrupt, OR of status |

## Verification
The assertions assume that the bus signals hold known values from the first clock edge and that reset is held for several cycles. Under that assumption, every `$past` sample after reset release sees reset-state registers. They also assume that a status write occupies a single cycle with a stable address. The bench therefore drives all bus inputs to idle at time zero, holds reset for five cycles and issues every access as a one-cycle strobe launched on a falling edge. The sweep toggles each active pin under each detection mode and lets the synchroniser settle before each read, so each expected value depends only on the armed mode and the pin level.

// File: rtl/gpio_evt_pkg.sv
// Shared definitions for the GPIO bank event detector.
// Assumes a 3-bit register address space; unused addresses read zero.
package gpio_evt_pkg;

    localparam int REG_ADDR_W = 3;

    // Register selector; the enable registers follow status in ascending order.
    typedef enum logic [REG_ADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_RISE   = 3'd1,
        REG_FALL   = 3'd2,
        REG_HIGH   = 3'd3,
        REG_LOW    = 3'd4
    } evt_reg_e;

    // Index of each enable kind inside the enable array.
    localparam int EN_RISE  = 0;
    localparam int EN_FALL  = 1;
    localparam int EN_HIGH  = 2;
    localparam int EN_LOW   = 3;
    localparam int EN_KINDS = 4;

endpackage

// File: rtl/gpio_evt_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pin levels.
// Assumes each pin is a quasi-static level; there is no bus coherency
// across pins. Output lags the input by STAGES clock edges.
module gpio_evt_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
// Per-pin edge and level detection on synchronised levels.
// Assumes lvl is already synchronous. An edge is seen as a difference
// between this cycle's level and the registered level of the previous cycle.
module gpio_evt_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] en_rise,
    input  logic [WIDTH-1:0] en_fall,
    input  logic [WIDTH-1:0] en_high,
    input  logic [WIDTH-1:0] en_low,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] prev_q;

    // Remember the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl;
        end
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rose;
        logic fell;

        // Combine the four armed conditions of one pin into one event.
        always_comb begin
            rose   = lvl[p] & ~prev_q[p];
            fell   = ~lvl[p] & prev_q[p];
            evt[p] = (rose & en_rise[p]) | (fell & en_fall[p])
                   | (lvl[p] & en_high[p]) | (~lvl[p] & en_low[p]);
        end
    end

endmodule

// File: rtl/gpio_evt_regs.sv
// Register file: four enable registers and a write-one-to-clear status.
// Assumes single-cycle accesses. A new event outranks a clear on the same
// bit. Bits at or above ACTIVE are held at zero.
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ACTIVE = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      evt,
    output logic [WIDTH-1:0]      en_rise,
    output logic [WIDTH-1:0]      en_fall,
    output logic [WIDTH-1:0]      en_high,
    output logic [WIDTH-1:0]      en_low,
    output logic [WIDTH-1:0]      status
);

    localparam logic [WIDTH-1:0] ACT_MASK = {WIDTH{1'b1}} >> (WIDTH - ACTIVE);

    logic [WIDTH-1:0] en_q [EN_KINDS];
    logic [WIDTH-1:0] status_q;
    logic             wr_any;
    logic [WIDTH-1:0] clr_mask;

    assign wr_any   = bus_valid && bus_write;
    assign clr_mask = (wr_any && bus_addr == REG_STATUS) ? bus_wdata : '0;

    for (genvar k = 0; k < EN_KINDS; k++) begin : g_en
        localparam logic [REG_ADDR_W-1:0] MY_ADDR = REG_ADDR_W'(int'(REG_RISE) + k);

        // Load one enable register on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[k] <= '0;
            end else if (wr_any && bus_addr == MY_ADDR) begin
                en_q[k] <= bus_wdata & ACT_MASK;
            end
        end
    end

    // Sticky status: clear the written ones, then let new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_mask) | evt) & ACT_MASK;
        end
    end

    // Return the selected register; unmapped addresses read zero.
    always_comb begin
        unique case (bus_addr)
            REG_STATUS: bus_rdata = status_q;
            REG_RISE:   bus_rdata = en_q[EN_RISE];
            REG_FALL:   bus_rdata = en_q[EN_FALL];
            REG_HIGH:   bus_rdata = en_q[EN_HIGH];
            REG_LOW:    bus_rdata = en_q[EN_LOW];
            default:    bus_rdata = '0;
        endcase
    end

    assign en_rise = en_q[EN_RISE];
    assign en_fall = en_q[EN_FALL];
    assign en_high = en_q[EN_HIGH];
    assign en_low  = en_q[EN_LOW];
    assign status  = status_q;

endmodule

// File: rtl/gpio_evt_bank.sv
// Top of the GPIO bank event detector: synchroniser, detector, registers
// and the bank interrupt. Assumes one instance per bank of up to NUM_PINS
// pins, of which ACTIVE_PINS (from bit 0 upward) are used.
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ACTIVE_PINS = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic                  irq
);

    logic [NUM_PINS-1:0] lvl_sync;
    logic [NUM_PINS-1:0] evt_raw;
    logic [NUM_PINS-1:0] en_rise;
    logic [NUM_PINS-1:0] en_fall;
    logic [NUM_PINS-1:0] en_high;
    logic [NUM_PINS-1:0] en_low;
    logic [NUM_PINS-1:0] status_q;

    gpio_evt_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    gpio_evt_detect #(
        .WIDTH (NUM_PINS)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .en_rise (en_rise),
        .en_fall (en_fall),
        .en_high (en_high),
        .en_low  (en_low),
        .evt     (evt_raw)
    );

    gpio_evt_regs #(
        .WIDTH  (NUM_PINS),
        .ACTIVE (ACTIVE_PINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt_raw),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .en_high   (en_high),
        .en_low    (en_low),
        .status    (status_q)
    );

    // Bank interrupt is the OR of every status bit.
    assign irq = |status_q;

endmodule

// File: rtl/gpio_evt_chk.sv
// Property checker for gpio_evt_bank, attached by bind.
// Assumes bus inputs are known from the first clock edge and reset is held
// for more than one cycle.
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ACTIVE_PINS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [NUM_PINS-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0]   status,
    input logic [NUM_PINS-1:0]   evt,
    input logic                  irq
);

    localparam logic [NUM_PINS-1:0] MASK = {NUM_PINS{1'b1}} >> (NUM_PINS - ACTIVE_PINS);

    logic wr_stat;
    assign wr_stat = bus_valid && bus_write && (bus_addr == REG_STATUS);

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != '0)); // R10

    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~MASK) == '0); // R12

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status & $past(bus_wdata) & ~$past(evt)) == '0)); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & MASK) != '0) |=> ((($past(evt) & MASK) & ~status) == '0)); // R9

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~status & ~($past(wr_stat) ? $past(bus_wdata) : '0)) == '0)); // R11

endmodule

bind gpio_evt_bank gpio_evt_chk #(
    .NUM_PINS    (NUM_PINS),
    .ACTIVE_PINS (ACTIVE_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status_q),
    .evt       (evt_raw),
    .irq       (irq)
);

// File: tb/gpio_evt_bank_test.sv
module gpio_evt_bank_test;

    localparam int W   = 32;
    localparam int ACT = 22;
    localparam logic [W-1:0] AMASK = {W{1'b1}} >> (W - ACT);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_evt_bank #(.NUM_PINS(W), .ACTIVE_PINS(ACT), .SYNC_STAGES(2)) uut (
        .clk (clk), .rst_n (rst_n), .pin_in (pin_in),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; holds the write over one rising edge.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_stat(input string req, input logic [W-1:0] exp);
        logic [W-1:0] v;
        rd(3'd0, v);
        check(req, v, exp);
        check({req, "/R10 irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, (exp != '0)});
    endtask

    initial begin
        logic [W-1:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 unmapped addresses
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, '0);
        end
        check("R1 reset irq", {{(W-1){1'b0}}, irq}, '0);

        // R2 readback and R12 masking of inert pins
        wr(3'd1, '1);          rd(3'd1, v); check("R2/R12 rise readback", v, AMASK);
        wr(3'd2, 32'h5A5A5A5A); rd(3'd2, v); check("R2/R12 fall readback", v, 32'h5A5A5A5A & AMASK);
        wr(3'd3, 32'h0000F00F); rd(3'd3, v); check("R2 high readback", v, 32'h0000F00F);
        wr(3'd4, 32'h00012345); rd(3'd4, v); check("R2 low readback", v, 32'h00012345);
        wr(3'd5, '1);           rd(3'd5, v); check("R2 unmapped write", v, '0);
        for (int a = 1; a < 5; a++) wr(3'(a), '0);
        wr(3'd0, '1);
        settle();

        // R12 inert pins never raise status
        wr(3'd1, '1); wr(3'd2, '1); wr(3'd3, '1);
        pin_in[25] = 1'b1; pin_in[31] = 1'b1;
        settle();
        chk_stat("R12 inert pins rise", '0);
        pin_in[25] = 1'b0; pin_in[31] = 1'b0;
        settle();
        chk_stat("R12 inert pins fall", '0);
        for (int a = 1; a < 5; a++) wr(3'(a), '0);

        // R3 exact latency: visible on third edge after change
        wr(3'd1, 32'h2);
        pin_in[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd0, v); check("R3 not yet after two edges", v, '0);
        @(negedge clk);
        rd(3'd0, v); check("R3 set on third edge", v, 32'h2);
        // R11 disabling enable keeps the bit; pin falling keeps it too
        wr(3'd1, '0);
        pin_in[1] = 1'b0;
        settle();
        chk_stat("R11 sticky after disable", 32'h2);
        wr(3'd0, '1);
        settle();
        chk_stat("R8 cleared", '0);

        // R9 event and clear in the same cycle
        wr(3'd1, 32'h1);
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(3'd0, '1);
        rd(3'd0, v); check("R9 event beats clear", v, 32'h1);
        wr(3'd1, '0);
        pin_in[0] = 1'b0;
        wr(3'd0, '1);
        settle();

        // Sweep: every active pin under every mode
        for (int mode = 0; mode < 5; mode++) begin
            string tag;
            case (mode)
                0: tag = "R3 rise";
                1: tag = "R4 fall";
                2: tag = "R5 both";
                3: tag = "R6 high";
                default: tag = "R7 low";
            endcase
            for (int p = 0; p < ACT; p++) begin
                logic [W-1:0] bitm, ea, eb, ec, ed;
                bool_sweep: begin
                    bitm = W'(1) << p;
                    for (int a = 1; a < 5; a++) wr(3'(a), '0);
                    case (mode)
                        0: wr(3'd1, bitm);
                        1: wr(3'd2, bitm);
                        2: begin wr(3'd1, bitm); wr(3'd2, bitm); end
                        3: wr(3'd3, bitm);
                        default: wr(3'd4, bitm);
                    endcase
                    settle();
                    wr(3'd0, '1);
                    settle();
                    ea = (mode == 4) ? bitm : '0;
                    chk_stat({tag, " idle low"}, ea);
                    pin_in[p] = 1'b1;
                    settle();
                    eb = ea | ((mode == 0 || mode == 2 || mode == 3) ? bitm : '0);
                    chk_stat({tag, " after rise"}, eb);
                    wr(3'd0, '0);
                    settle();
                    chk_stat({tag, " R8 zero write"}, eb);
                    wr(3'd0, bitm);
                    settle();
                    ec = (mode == 3) ? bitm : '0;
                    chk_stat({tag, " R8 clear while high"}, ec);
                    pin_in[p] = 1'b0;
                    settle();
                    ed = ec | ((mode == 1 || mode == 2 || mode == 4) ? bitm : '0);
                    chk_stat({tag, " after fall"}, ed);
                    wr(3'd0, '1);
                    settle();
                    chk_stat({tag, " clear while low"}, ea);
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule